// File: doc/BRIEF.md
# Majority Voter with Spare Substitution

The block sits downstream of a pool of identical, lockstepped units. At any time a subset of the pool is connected to the vote. The block forwards the word on which a strict majority of the connected units agree, so a single faulty unit is masked without a gap in the output stream. A unit that disagrees with a valid majority is treated as wholly failed. It is retired for good, and its enable and power requests drop. On the same edge the lowest-numbered unused spare is powered up. That spare joins the vote only after it reports that it has synchronised with the shared input, so the number of voting units returns to its starting value.

When the spares are used up, retirements shrink the voting set. If the optional fallback is enabled and a retirement leaves two healthy units with no spare, the block powers one of them off and forwards the other alone. Error detection is lost in that mode. If at any point the connected units have no strict majority, the block raises a sticky fatal flag and stops producing valid words.

Top module: `nmr_spare_voter`

## Requirements
- R1: After reset, units 0 to N-S-1 have power and enable asserted, the S spare units have neither, and votedValid, voteMismatch, simplexMode and noMajority are low with no unit marked retired.
- R2: A vote is taken in a cycle only when every connected unit asserts its valid strobe. Data and strobes from units that are not connected are ignored. A vote's result appears on votedData/votedValid one clock after the inputs; votedValid is low and votedData holds its value in any cycle without a vote.
- R3: votedData is the word held by more than half of the connected units. voteMismatch pulses, in the same cycle as the result, whenever any connected unit differs from that word.
- R4: A connected unit outside the majority is retired on the voting edge. From the next cycle its unitRetired bit is set, and its unitEnable and unitPower bits are clear; a retired unit never returns.
- R5: On the edge that retires a unit, the lowest-indexed unused spare gets unitPower. It gets unitEnable one cycle after the first edge at which its unitReady is sampled high. It stays connected afterwards even if unitReady falls.
- R6: Each spare is powered at most once, at most one per edge, and once all S spares are in use a retirement powers no unit.
- R7: With fallbackEn high, a retirement that leaves exactly two healthy powered units and no spare powers off the higher-indexed of the two and sets simplexMode. The lone unit's word is then forwarded on each of its valid strobes with voteMismatch low, and data from any other unit is ignored.
- R8: With fallbackEn low, the same situation keeps both healthy units connected and simplexMode low.
- R9: If the connected units have no strict majority in a vote cycle, votedValid stays low, voteMismatch pulses, and noMajority rises and stays high until reset. From then on no vote, retirement or spare power-up happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fallbackEn | input | 1 | Allows the drop to single-unit mode |
| unitData | input | N*W | Unit output words, unit i at bits i*W +: W |
| unitValid | input | N | Per-unit word valid strobe |
| unitReady | input | N | Per-unit synchronised indication, used for spares |
| votedData | output | W | Voted word |
| votedValid | output | 1 | One-cycle pulse for each vote result |
| voteMismatch | output | 1 | A connected unit disagreed in the last vote |
| unitEnable | output | N | Unit is connected to the vote |
| unitPower | output | N | Power request per unit |
| unitRetired | output | N | Unit has been retired permanently |
| simplexMode | output | 1 | Single-unit operation, no error detection |
| noMajority | output | 1 | Sticky fatal: a vote found no strict majority |

## Verification
The assertions assume that the connected units present their strobes in lockstep and that a spare raises its ready flag only after it has been powered. They also assume that reset is asserted at time zero. The stimulus keeps to these assumptions. It raises a spare's ready bit only in cycles after its power request was seen high. It corrupts at most one connected unit per vote while a majority can still exist, and it forces the no-majority case only once the set has shrunk to two disagreeing units. It feeds unrelated words and strobes to unconnected units to show they are ignored.

// File: rtl/nmr_pkg.sv
package nmr_pkg;

  // Strobes passed from the spare controller to the voting datapath
  typedef struct packed {
    logic sample;   // every connected unit is valid this cycle
    logic lockout;  // fatal state reached, suppress all results
  } voteStrobe_t;

endpackage

// File: rtl/nmr_vote_path.sv
module nmr_vote_path
  import nmr_pkg::*;
#(
  parameter int unsigned N = 5,
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N*W-1:0] unitData,
  input  logic [N-1:0]   voters,
  input  voteStrobe_t    strobe,
  output logic [N-1:0]   majMask,
  output logic           haveMaj,
  output logic [W-1:0]   votedData,
  output logic           votedValid,
  output logic           voteMismatch
);

  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] nVoters;
  logic [W-1:0]  pick;
  logic          found;
  logic          resultGo;

  assign nVoters = CW'($countones(voters));

  // Each connected unit counts how many connected units share its word
  for (genvar i = 0; i < N; i++) begin : g_agree
    logic [CW-1:0] agree;
    always_comb begin
      agree = '0;
      for (int j = 0; j < N; j++) begin
        if (voters[j] && (unitData[j*W +: W] == unitData[i*W +: W])) begin
          agree = agree + CW'(1);
        end
      end
    end
    assign majMask[i] = voters[i] && ({agree, 1'b0} > {1'b0, nVoters});
  end

  assign haveMaj = |majMask;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (majMask[i] && !found) begin
        pick  = unitData[i*W +: W];
        found = 1'b1;
      end
    end
  end

  assign resultGo = strobe.sample && !strobe.lockout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      votedData    <= '0;
      votedValid   <= 1'b0;
      voteMismatch <= 1'b0;
    end else begin
      votedValid   <= resultGo && haveMaj;
      voteMismatch <= resultGo && ((voters & ~majMask) != '0);
      if (resultGo && haveMaj) votedData <= pick;
    end
  end

  // R9
  lockout_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockout |=> !votedValid);

  // R2
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    votedValid |-> $past(strobe.sample));

endmodule

// File: rtl/nmr_spare_ctrl.sv
module nmr_spare_ctrl
  import nmr_pkg::*;
#(
  parameter int unsigned N = 5,
  parameter int unsigned S = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fallbackEn,
  input  logic [N-1:0] unitValid,
  input  logic [N-1:0] unitReady,
  input  logic [N-1:0] majMask,
  input  logic         haveMaj,
  output voteStrobe_t  strobe,
  output logic [N-1:0] voters,
  output logic [N-1:0] unitPower,
  output logic [N-1:0] unitRetired,
  output logic         simplexMode,
  output logic         noMajority
);

  localparam int unsigned ACT = N - S;
  localparam logic [N-1:0] ACT_MASK   = {{S{1'b0}}, {ACT{1'b1}}};
  localparam logic [N-1:0] SPARE_MASK = ~ACT_MASK;

  logic [N-1:0] poweredQ, retiredQ, syncedQ, spareQ;
  logic [N-1:0] poweredD, spareD;
  logic         simplexQ, simplexD, fatalQ;
  logic [N-1:0] retireNow, nextSpare, survivors, keepOne;
  logic         allValid;

  assign voters    = poweredQ & ~retiredQ & syncedQ;
  assign unitPower = poweredQ & ~retiredQ;
  assign allValid  = &(unitValid | ~voters);

  assign strobe.sample  = allValid && (voters != '0) && !fatalQ;
  assign strobe.lockout = fatalQ;

  assign retireNow = (strobe.sample && haveMaj) ? (voters & ~majMask) : '0;
  assign survivors = poweredQ & ~retiredQ & ~retireNow;

  always_comb begin
    nextSpare = '0;
    keepOne   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (spareQ[i]) begin
        nextSpare    = '0;
        nextSpare[i] = 1'b1;
      end
      if (survivors[i]) begin
        keepOne    = '0;
        keepOne[i] = 1'b1;
      end
    end
  end

  always_comb begin
    poweredD = poweredQ;
    spareD   = spareQ;
    simplexD = simplexQ;
    if (retireNow != '0) begin
      if (spareQ != '0) begin
        poweredD = poweredQ | nextSpare;
        spareD   = spareQ & ~nextSpare;
      end else if (fallbackEn && !simplexQ && ($countones(survivors) == 2)) begin
        poweredD = poweredQ & ~(survivors & ~keepOne);
        simplexD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      poweredQ <= ACT_MASK;
      syncedQ  <= ACT_MASK;
      spareQ   <= SPARE_MASK;
      retiredQ <= '0;
      simplexQ <= 1'b0;
      fatalQ   <= 1'b0;
    end else begin
      poweredQ <= poweredD;
      spareQ   <= spareD;
      simplexQ <= simplexD;
      retiredQ <= retiredQ | retireNow;
      syncedQ  <= syncedQ | (poweredQ & ~retiredQ & unitReady);
      fatalQ   <= fatalQ | (strobe.sample && !haveMaj);
    end
  end

  assign unitRetired = retiredQ;
  assign simplexMode = simplexQ;
  assign noMajority  = fatalQ;

  // R4
  retired_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retiredQ & $past(retiredQ)) == $past(retiredQ));

  // R5
  spare_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((unitPower & ~$past(unitPower)) & ~$past(spareQ)) == '0);

  // R6
  one_spare_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(unitPower & ~$past(unitPower)));

  // R9
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(fatalQ) |-> noMajority);

  // R7
  simplex_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    simplexQ |-> ($countones(voters) <= 1));

endmodule

// File: rtl/nmr_spare_voter.sv
module nmr_spare_voter
  import nmr_pkg::*;
#(
  parameter int unsigned N = 5,
  parameter int unsigned S = 2,
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fallbackEn,
  input  logic [N*W-1:0] unitData,
  input  logic [N-1:0]   unitValid,
  input  logic [N-1:0]   unitReady,
  output logic [W-1:0]   votedData,
  output logic           votedValid,
  output logic           voteMismatch,
  output logic [N-1:0]   unitEnable,
  output logic [N-1:0]   unitPower,
  output logic [N-1:0]   unitRetired,
  output logic           simplexMode,
  output logic           noMajority
);

  voteStrobe_t  strobe;
  logic [N-1:0] voters, majMask;
  logic         haveMaj;

  nmr_spare_ctrl #(.N(N), .S(S)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fallbackEn (fallbackEn),
    .unitValid  (unitValid),
    .unitReady  (unitReady),
    .majMask    (majMask),
    .haveMaj    (haveMaj),
    .strobe     (strobe),
    .voters     (voters),
    .unitPower  (unitPower),
    .unitRetired(unitRetired),
    .simplexMode(simplexMode),
    .noMajority (noMajority)
  );

  nmr_vote_path #(.N(N), .W(W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .unitData    (unitData),
    .voters      (voters),
    .strobe      (strobe),
    .majMask     (majMask),
    .haveMaj     (haveMaj),
    .votedData   (votedData),
    .votedValid  (votedValid),
    .voteMismatch(voteMismatch)
  );

  assign unitEnable = voters;

endmodule

// File: tb/test_nmr_spare_voter.sv
`timescale 1ns/1ps
module test_nmr_spare_voter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fallbackEn = 1'b1;
  logic [39:0] unitData = '0;
  logic [4:0]  unitValid = '0;
  logic [4:0]  unitReady = '0;
  logic [7:0]  votedData;
  logic        votedValid, voteMismatch, simplexMode, noMajority;
  logic [4:0]  unitEnable, unitPower, unitRetired;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic       v, mis, sx, fa;
    logic [4:0] pw, en, rt;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  nmr_spare_voter i_nmr_spare_voter (
    .clk(clk), .rstN(rstN), .fallbackEn(fallbackEn),
    .unitData(unitData), .unitValid(unitValid), .unitReady(unitReady),
    .votedData(votedData), .votedValid(votedValid), .voteMismatch(voteMismatch),
    .unitEnable(unitEnable), .unitPower(unitPower), .unitRetired(unitRetired),
    .simplexMode(simplexMode), .noMajority(noMajority)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] d0, d1, d2, d3, d4,
                      input logic [4:0] vld, rdy,
                      input logic [7:0] ed, input logic ev, emis,
                      input logic [4:0] epw, een, ert,
                      input logic esx, efa, input string tag);
    exp_t e;
    @(negedge clk);
    unitData  = {d4, d3, d2, d1, d0};
    unitValid = vld;
    unitReady = rdy;
    e.d = ed; e.v = ev; e.mis = emis; e.pw = epw; e.en = een; e.rt = ert;
    e.sx = esx; e.fa = efa; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops one expectation per clock after each driven step
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp(e.tag, "votedData", votedData, e.d);
      cmp(e.tag, "votedValid", {7'd0, votedValid}, {7'd0, e.v});
      cmp(e.tag, "voteMismatch", {7'd0, voteMismatch}, {7'd0, e.mis});
      cmp(e.tag, "unitPower", {3'd0, unitPower}, {3'd0, e.pw});
      cmp(e.tag, "unitEnable", {3'd0, unitEnable}, {3'd0, e.en});
      cmp(e.tag, "unitRetired", {3'd0, unitRetired}, {3'd0, e.rt});
      cmp(e.tag, "simplexMode", {7'd0, simplexMode}, {7'd0, e.sx});
      cmp(e.tag, "noMajority", {7'd0, noMajority}, {7'd0, e.fa});
    end
  end

  task automatic idleAndDrain();
    @(negedge clk);
    unitValid = '0;
    unitReady = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic resetCheck();
    cmp("R1", "unitPower", {3'd0, unitPower}, 8'h07);
    cmp("R1", "unitEnable", {3'd0, unitEnable}, 8'h07);
    cmp("R1", "unitRetired", {3'd0, unitRetired}, 8'h00);
    cmp("R1", "flags", {4'd0, votedValid, voteMismatch, simplexMode, noMajority}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    resetCheck();

    // Run 1: fallback enabled, spares consumed, then single-unit mode
    step(8'h11, 8'h11, 8'h11, 8'h00, 8'h00, 5'b00111, 5'b00000,
         8'h11, 1, 0, 5'b00111, 5'b00111, 5'b00000, 0, 0, "R3 agree");
    step(8'h22, 8'h22, 8'h22, 8'h99, 8'h00, 5'b00101, 5'b00000,
         8'h11, 0, 0, 5'b00111, 5'b00111, 5'b00000, 0, 0, "R2 strobe missing");
    step(8'h33, 8'h44, 8'h33, 8'h00, 8'h00, 5'b00111, 5'b00000,
         8'h33, 1, 1, 5'b01101, 5'b00101, 5'b00010, 0, 0, "R4 retire unit1");
    step(8'h55, 8'h00, 8'h55, 8'h77, 8'h00, 5'b01101, 5'b00000,
         8'h55, 1, 0, 5'b01101, 5'b00101, 5'b00010, 0, 0, "R5 spare not ready");
    step(8'h66, 8'h00, 8'h66, 8'h66, 8'h00, 5'b01101, 5'b01000,
         8'h66, 1, 0, 5'b01101, 5'b01101, 5'b00010, 0, 0, "R5 spare joins");
    step(8'h12, 8'h00, 8'h12, 8'h12, 8'h00, 5'b01101, 5'b01000,
         8'h12, 1, 0, 5'b01101, 5'b01101, 5'b00010, 0, 0, "R3 three voters");
    step(8'hAA, 8'h00, 8'h21, 8'h21, 8'h00, 5'b01101, 5'b00000,
         8'h21, 1, 1, 5'b11100, 5'b01100, 5'b00011, 0, 0, "R5 latched ready, retire unit0");
    step(8'h00, 8'h00, 8'h31, 8'h31, 8'h31, 5'b11100, 5'b10000,
         8'h31, 1, 0, 5'b11100, 5'b11100, 5'b00011, 0, 0, "R6 last spare joins");
    step(8'h00, 8'h00, 8'h41, 8'h41, 8'h40, 5'b11100, 5'b00000,
         8'h41, 1, 1, 5'b00100, 5'b00100, 5'b10011, 1, 0, "R7 fallback to single unit");
    step(8'h01, 8'h02, 8'h5A, 8'h03, 8'h04, 5'b11111, 5'b11111,
         8'h5A, 1, 0, 5'b00100, 5'b00100, 5'b10011, 1, 0, "R7 single unit forwards");
    step(8'hEE, 8'hEE, 8'h5B, 8'hEE, 8'hEE, 5'b11111, 5'b00000,
         8'h5B, 1, 0, 5'b00100, 5'b00100, 5'b10011, 1, 0, "R7 no detection");
    step(8'hEE, 8'hEE, 8'h5C, 8'hEE, 8'hEE, 5'b11011, 5'b00000,
         8'h5B, 0, 0, 5'b00100, 5'b00100, 5'b10011, 1, 0, "R2 single unit idle");
    idleAndDrain();

    // Run 2: fallback disabled, duplex continues until a split vote
    @(negedge clk);
    rstN = 1'b0;
    fallbackEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    resetCheck();
    step(8'h01, 8'h02, 8'h02, 8'h00, 8'h00, 5'b00111, 5'b00000,
         8'h02, 1, 1, 5'b01110, 5'b00110, 5'b00001, 0, 0, "R4 retire unit0");
    step(8'h00, 8'h03, 8'h03, 8'h03, 8'h00, 5'b01110, 5'b01000,
         8'h03, 1, 0, 5'b01110, 5'b01110, 5'b00001, 0, 0, "R5 spare3 joins");
    step(8'h00, 8'h04, 8'h05, 8'h05, 8'h00, 5'b01110, 5'b01000,
         8'h05, 1, 1, 5'b11100, 5'b01100, 5'b00011, 0, 0, "R6 second spare powered");
    step(8'h00, 8'h00, 8'h06, 8'h06, 8'h06, 5'b11100, 5'b11000,
         8'h06, 1, 0, 5'b11100, 5'b11100, 5'b00011, 0, 0, "R5 spare4 joins");
    step(8'h00, 8'h00, 8'h07, 8'h08, 8'h08, 5'b11100, 5'b11000,
         8'h08, 1, 1, 5'b11000, 5'b11000, 5'b00111, 0, 0, "R8 duplex kept, R6 none left");
    step(8'h00, 8'h00, 8'h00, 8'h09, 8'h0A, 5'b11000, 5'b11000,
         8'h08, 0, 1, 5'b11000, 5'b11000, 5'b00111, 0, 1, "R9 split vote");
    step(8'h00, 8'h00, 8'h00, 8'h0B, 8'h0B, 5'b11000, 5'b11000,
         8'h08, 0, 0, 5'b11000, 5'b11000, 5'b00111, 0, 1, "R9 locked out");
    idleAndDrain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule